// File: doc/BRIEF.md
# Programmable UART baud-rate generator

This block produces the timing enables that a UART's shifter uses for transmission and sampling. It runs on the platform clock. A fixed prescaler first halves that clock. A 16-bit reloadable down-counter then divides the halved rate by a programmable divisor. Each time the counter expires, the block emits a single-clock oversample enable, which runs at sixteen times the line rate. A small sub-divider counts those enables and marks every sixteenth one with a baud tick.

Software sets the divisor through two byte-wide latches, one for the low byte and one for the high byte, and can read either latch back. Storing a byte restarts the down-counter at once from the new combined divisor. A new rate therefore takes effect without waiting for the old period to run out. A divisor of zero stops the generator.

With divisor D and platform clock f, the oversample enable runs at f / (2·D) and the baud rate is f / (32·D).

Top module: `baud_gen_top`

## Requirements
- R1: After a synchronous reset, both divisor latches read 0x00 and neither `os_tick` nor `baud_tick` is asserted.
- R2: While the combined divisor is zero, `os_tick` and `baud_tick` stay low.
- R3: With a nonzero divisor D (1 to 65535), `os_tick` is a one-clock pulse repeating every 2·D clock cycles.
- R4: A write with `reg_sel` = 0 replaces bits 7:0 of the divisor, and a write with `reg_sel` = 1 replaces bits 15:8. The other byte is left unchanged. `reg_rdata` returns the latch chosen by `reg_sel` in the same cycle.
- R5: A write to either latch reloads the down-counter on that clock edge. `os_tick` is low in the cycle after the write. The first pulse after the write comes 2·D−1 or 2·D clocks after the write edge, depending on the prescaler phase.
- R6: `baud_tick` is asserted together with every sixteenth `os_tick` and never without it, so it repeats every 32·D clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Platform clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Writes `reg_wdata` into the selected divisor latch |
| reg_sel | input | 1 | Latch select: 0 = low byte, 1 = high byte |
| reg_wdata | input | 8 | Byte to store |
| reg_rdata | output | 8 | Contents of the selected latch |
| os_tick | output | 1 | Oversample enable at sixteen times the baud rate |
| baud_tick | output | 1 | Enable at the baud rate |

## Verification
The bench looks at the extreme and partial divisor settings. A divisor of 1 must give a pulse on every other clock; an off-by-one in the terminal compare would halve that rate or stall it. A write to only the high byte, and then to only the low byte, must change the period at once. A design that waited for the old count to expire, or that reloaded only on one byte, would show a stale first gap. Clearing the divisor to zero must silence both outputs; a counter that wrapped through zero would keep ticking every 65536 prescaled cycles. A behavioural model, compared on every clock, catches a baud tick that slips by one oversample enable.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int unsigned DEF_DIV_W      = 16;
    localparam int unsigned DEF_BYTE_W     = 8;
    localparam int unsigned DEF_PRE_DIV    = 2;
    localparam int unsigned DEF_OVERSAMPLE = 16;

    typedef enum logic [0:0] {
        SEL_LOW  = 1'b0,
        SEL_HIGH = 1'b1
    } byte_sel_e;

    typedef struct packed {
        logic os;
        logic baud;
    } tick_pair_s;

    function automatic int unsigned sel_width(input int unsigned n_bytes);
        return (n_bytes > 1) ? $clog2(n_bytes) : 1;
    endfunction

endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs
    import baud_pkg::*;
#(
    parameter int unsigned DIV_W  = DEF_DIV_W,
    parameter int unsigned BYTE_W = DEF_BYTE_W,
    localparam int unsigned NB    = DIV_W / BYTE_W,
    localparam int unsigned SEL_W = sel_width(NB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [DIV_W-1:0]  divisor,
    output logic [DIV_W-1:0]  next_div
);

    logic [BYTE_W-1:0] bytes_q [NB];

    for (genvar g = 0; g < NB; g++) begin : g_byte
        logic hit;
        assign hit = wr_en && (sel == SEL_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                bytes_q[g] <= '0;
            end else if (hit) begin
                bytes_q[g] <= wdata;
            end
        end

        assign divisor[g*BYTE_W +: BYTE_W]  = bytes_q[g];
        assign next_div[g*BYTE_W +: BYTE_W] = hit ? wdata : bytes_q[g];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NB; i++) begin
            if (sel == SEL_W'(i)) begin
                rdata = bytes_q[i];
            end
        end
    end

endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
    parameter int unsigned PRE_DIV = baud_pkg::DEF_PRE_DIV,
    localparam int unsigned PRE_W  = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    output logic ce
);

    logic [PRE_W-1:0] pre_q;

    assign ce = (pre_q == PRE_W'(PRE_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (ce) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    AST_CE_SPACED: assert property (@(posedge clk) disable iff (rst)
        ce |=> !ce); // R3

endmodule

// File: rtl/baud_counter.sv
module baud_counter #(
    parameter int unsigned DIV_W = baud_pkg::DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    input  logic [DIV_W-1:0] divisor,
    output logic             fire
);

    logic [DIV_W-1:0] cnt_q;
    logic             active;
    logic             terminal;

    assign active   = (divisor != '0);
    assign terminal = (cnt_q <= DIV_W'(1));
    assign fire     = ce && !load && active && terminal;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (ce && active) begin
            cnt_q <= terminal ? divisor : cnt_q - 1'b1;
        end
    end

    AST_RELOAD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == divisor)); // R5

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (divisor != '0) |-> ((cnt_q != '0) && (cnt_q <= divisor))); // R3

endmodule

// File: rtl/baud_subdiv.sv
module baud_subdiv
    import baud_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = DEF_OVERSAMPLE,
    localparam int unsigned SUB_W     = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    output tick_pair_s ticks
);

    logic [SUB_W-1:0] sub_q;
    logic             wrap;

    assign wrap = (sub_q == SUB_W'(OVERSAMPLE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= '0;
            ticks <= '0;
        end else begin
            ticks.os   <= fire;
            ticks.baud <= fire && wrap;
            if (fire) begin
                sub_q <= wrap ? '0 : sub_q + 1'b1;
            end
        end
    end

    AST_BAUD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        ticks.baud |-> ticks.os); // R6

endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top
    import baud_pkg::*;
#(
    parameter int unsigned DIV_W      = DEF_DIV_W,
    parameter int unsigned BYTE_W     = DEF_BYTE_W,
    parameter int unsigned PRE_DIV    = DEF_PRE_DIV,
    parameter int unsigned OVERSAMPLE = DEF_OVERSAMPLE,
    localparam int unsigned SEL_W     = sel_width(DIV_W / BYTE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              os_tick,
    output logic              baud_tick
);

    logic [DIV_W-1:0] divisor;
    logic [DIV_W-1:0] next_div;
    logic             ce;
    logic             fire;
    tick_pair_s       ticks;

    baud_div_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .divisor  (divisor),
        .next_div (next_div)
    );

    baud_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk (clk),
        .rst (rst),
        .ce  (ce)
    );

    baud_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .load     (reg_wr_en),
        .load_val (next_div),
        .divisor  (divisor),
        .fire     (fire)
    );

    baud_subdiv #(.OVERSAMPLE(OVERSAMPLE)) u_sub (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .ticks (ticks)
    );

    assign os_tick   = ticks.os;
    assign baud_tick = ticks.baud;

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        ($past(divisor) == '0) |-> !os_tick); // R2

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !os_tick); // R5

endmodule

// File: tb/baud_gen_top_tb_top.sv
module baud_gen_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr_en = 1'b0;
    logic [0:0] reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       os_tick;
    logic       baud_tick;

    int total = 0;
    int bad   = 0;
    bit cmp_on = 1'b0;

    // behavioural reference state
    int m_lo, m_hi, m_cnt, m_phase, m_sub, m_dv;
    bit m_go, e_os, e_baud;

    always #4 clk = ~clk;

    baud_gen_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr_en (reg_wr_en),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .os_tick   (os_tick),
        .baud_tick (baud_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_lo = 0; m_hi = 0; m_cnt = 0; m_phase = 0; m_sub = 0;
            e_os = 0; e_baud = 0;
        end else begin
            m_dv   = m_hi * 256 + m_lo;
            m_go   = (m_phase == 1) && !reg_wr_en && (m_dv != 0) && (m_cnt <= 1);
            e_os   = m_go;
            e_baud = m_go && (m_sub == 15);
            if (m_go) m_sub = (m_sub + 1) % 16;
            if (reg_wr_en) begin
                if (reg_sel == 1'b1) m_hi = int'(reg_wdata);
                else m_lo = int'(reg_wdata);
                m_cnt = m_hi * 256 + m_lo;
            end else if (m_phase == 1 && m_dv != 0) begin
                m_cnt = (m_cnt <= 1) ? m_dv : m_cnt - 1;
            end
            m_phase = 1 - m_phase;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            check(os_tick === e_os, "R3 model os_tick", int'(os_tick), int'(e_os));
            check(baud_tick === e_baud, "R6 model baud_tick", int'(baud_tick), int'(e_baud));
        end
    end

    task automatic write_byte(input bit hi, input int val);
        @(negedge clk);
        reg_sel   = hi;
        reg_wdata = 8'(val);
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic read_byte(input bit hi, output int val);
        reg_sel = hi;
        #1;
        val = int'(reg_rdata);
    endtask

    task automatic first_delay(output int n);
        n = 0;
        while (!os_tick) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic os_gap(output int n);
        while (!os_tick) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!os_tick);
    endtask

    task automatic baud_gap(output int n);
        while (!baud_tick) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!baud_tick);
    endtask

    task automatic run_divisor(input int d, input bit hi, input int val, input string tag);
        int n;
        write_byte(hi, val);
        first_delay(n);
        check(n == 2*d - 1 || n == 2*d, {tag, " R5 first pulse after write"}, n, 2*d);
        for (int k = 0; k < 3; k++) begin
            os_gap(n);
            check(n == 2*d, {tag, " R3 os_tick period"}, n, 2*d);
        end
    endtask

    initial begin
        int v, n, cnt;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;

        // R1: reset values
        check(os_tick == 1'b0, "R1 os_tick after reset", int'(os_tick), 0);
        check(baud_tick == 1'b0, "R1 baud_tick after reset", int'(baud_tick), 0);
        read_byte(1'b0, v); check(v == 0, "R1 low latch after reset", v, 0);
        read_byte(1'b1, v); check(v == 0, "R1 high latch after reset", v, 0);

        // R2: zero divisor is silent
        cnt = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (os_tick || baud_tick) cnt++;
        end
        check(cnt == 0, "R2 pulses with zero divisor", cnt, 0);

        // divisor 3 via low byte
        run_divisor(3, 1'b0, 3, "div3");
        read_byte(1'b0, v); check(v == 3, "R4 low latch readback", v, 3);
        baud_gap(n); check(n == 96, "R6 baud_tick period div3", n, 96);
        baud_gap(n); check(n == 96, "R6 baud_tick period div3 again", n, 96);

        // minimum divisor
        run_divisor(1, 1'b0, 1, "div1");
        baud_gap(n); check(n == 32, "R6 baud_tick period div1", n, 32);

        // high byte only -> 0x0101
        run_divisor(257, 1'b1, 1, "hi_only");
        read_byte(1'b1, v); check(v == 1, "R4 high latch readback", v, 1);
        read_byte(1'b0, v); check(v == 1, "R4 low latch kept", v, 1);

        // low byte only -> 0x0105
        run_divisor(261, 1'b0, 5, "lo_only");
        read_byte(1'b1, v); check(v == 1, "R4 high latch kept", v, 1);

        // odd divisor with both bytes: 0x0007
        write_byte(1'b1, 0);
        run_divisor(7, 1'b0, 7, "div7");

        // back to zero: silent
        write_byte(1'b0, 0);
        cnt = 0;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            if (os_tick || baud_tick) cnt++;
        end
        check(cnt == 0, "R2 pulses after clearing divisor", cnt, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule